// File: doc/BRIEF.md
# Cascaded-Level Area and Dwell-Time Modulator

This block drives the level selection of a three-module cascaded three-level rectifier. Each carrier period it takes a signed sine sample and a modulation index and scales them into a voltage reference, where full scale stands for six module voltages. It then locates the band between two adjacent total levels, out of the thirteen levels from -6E to +6E, that holds the reference. It also judges whether the reference is rising or falling.

From the band and the direction, the block picks the two bounding levels, A and B. When the reference rises, A is the lower level. When it falls, A is the upper level. The block computes how many clock ticks each level must be applied so that the period average equals the reference. It drives a select line that is high while A is applied. It pulses a trigger at the start of any period in which the band changes or the reference turns at a peak or trough, so that downstream logic can allocate a new level pair to the modules.

Top module: `lvl_dwell_mod`

## Requirements
- R1: After reset the band index is 1, the sign output is low, the direction output is rising, the trigger is low, A is level 0, B is level +1, A's on-time equals the full period, and select is high.
- R2: The magnitude is min(32767, floor(|sine| * min(M, 32768) / 32768)), where M is the unsigned index with 32768 meaning 1.0 and sine is two's complement. The band index is floor(6 * magnitude / 32768) + 1, in the range 1 to 6.
- R3: The sign output is high only when the sine sample is negative and the magnitude is non-zero.
- R4: Let f = 6 * magnitude mod 32768. The on-time of the level nearer zero is floor(PER * (32768 - f) / 32768) ticks. The other level gets the rest of the PER-tick period, so the two on-times sum to PER.
- R5: For band k, the bounding levels are k-1 and k when the sign is positive, and -k and -(k-1) when it is negative. A is the lower of the two when rising and the upper when falling. B is the other.
- R6: ta_ticks is the on-time of level A and tb_ticks the on-time of level B.
- R7: The signed reference is the magnitude with the sign applied. Direction becomes rising when the new reference exceeds the previous sample by more than 1, and falling when it is more than 1 below. Otherwise it keeps its old value.
- R8: The trigger is high for exactly the first cycle of a period when the band index, the sign or the direction differs from the previous period. It is low in every other cycle.
- R9: Select is high for the first ta_ticks cycles of each period, counted from the period's first cycle, and low for the rest.
- R10: Inputs are sampled in the last cycle of each period. All outputs except select hold steady for the whole following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sin_in | input | 16 | Signed sine sample, Q1.15 |
| m_idx | input | 16 | Modulation index, 32768 = 1.0, larger values clamp |
| area | output | 3 | Band index 1..6 |
| neg | output | 1 | Reference is negative |
| rising | output | 1 | Reference direction, 1 = rising |
| trig | output | 1 | One-cycle pulse requesting a new level pair |
| sel_a | output | 1 | High while level A is applied |
| lvl_a | output | 4 | Signed level A in units of E |
| lvl_b | output | 4 | Signed level B in units of E |
| ta_ticks | output | CW | On-time of A in clock ticks |
| tb_ticks | output | CW | On-time of B in clock ticks |

## Verification
The bench builds the block with a 16-tick carrier period, so the full period is short enough that every select pattern from 0 to 16 ticks can be checked cycle by cycle. It sweeps a triangular sine over the full signed range at several modulation indices, including zero and an over-range value. This covers all twelve bands, both zero-crossings, the most negative sample and both turning points. A short plateau sequence exercises the one-LSB deadband on direction.

// File: rtl/lvl_mod_pkg.sv
package lvl_mod_pkg;

  // Scaled reference magnitude, 0..32767 (Q0.15 of 6E)
  function automatic logic [14:0] scaled_mag(input logic signed [15:0] s,
                                             input logic [15:0] m);
    logic signed [16:0] se;
    logic [16:0] a;
    logic [16:0] mc;
    logic [33:0] p;
    logic [18:0] q;
    se = 17'(s);
    a  = se[16] ? 17'(-se) : 17'(se);
    mc = (m > 16'd32768) ? 17'd32768 : {1'b0, m};
    p  = 34'(a) * 34'(mc);
    q  = 19'(p >> 15);
    return (q > 19'd32767) ? 15'h7fff : q[14:0];
  endfunction

  function automatic logic [2:0] area_of(input logic [14:0] mag);
    logic [17:0] x;
    x = 18'(mag) * 18'd6;
    return x[17:15] + 3'd1;
  endfunction

  function automatic logic [14:0] frac_of(input logic [14:0] mag);
    logic [17:0] x;
    x = 18'(mag) * 18'd6;
    return x[14:0];
  endfunction

  // On-time in ticks of the level nearer zero
  function automatic logic [31:0] inner_ticks(input logic [14:0] frac,
                                              input logic [31:0] per);
    logic [47:0] p;
    p = 48'(16'd32768 - 16'(frac)) * 48'(per);
    return 32'(p >> 15);
  endfunction

endpackage

// File: rtl/lvl_period_timer.sv
module lvl_period_timer #(
  parameter int unsigned PER_TICKS = 66667,
  parameter int unsigned CW        = $clog2(PER_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = (cnt == CW'(PER_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  // R10: a period boundary always restarts the count
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt == '0));
endmodule

// File: rtl/lvl_ref_split.sv
module lvl_ref_split
  import lvl_mod_pkg::*;
(
  input  logic signed [15:0] sin_in,
  input  logic [15:0]        m_idx,
  output logic [14:0]        mag,
  output logic [2:0]         area,
  output logic [14:0]        frac,
  output logic               neg,
  output logic signed [15:0] ref_s
);
  assign mag   = scaled_mag(sin_in, m_idx);
  assign area  = area_of(mag);
  assign frac  = frac_of(mag);
  assign neg   = sin_in[15] && (mag != '0);
  assign ref_s = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  // R2: band index never leaves 1..6
  always_comb begin
    assert_band_range_R2: assert (area >= 3'd1 && area <= 3'd6);
  end
endmodule

// File: rtl/lvl_slope_track.sv
module lvl_slope_track (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic signed [15:0] ref_s,
  output logic               rise_nx,
  output logic               rise_q
);
  logic signed [15:0] prev_q;
  logic signed [16:0] diff;

  assign diff = 17'(ref_s) - 17'(prev_q);

  always_comb begin
    if (diff > 17'sd1)       rise_nx = 1'b1;
    else if (diff < -17'sd1) rise_nx = 1'b0;
    else                     rise_nx = rise_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      rise_q <= 1'b1;
    end else if (en) begin
      prev_q <= ref_s;
      rise_q <= rise_nx;
    end
  end

  // R7: direction is held between samples
  assert_slope_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rise_q));
endmodule

// File: rtl/lvl_dwell_mod.sv
module lvl_dwell_mod
  import lvl_mod_pkg::*;
#(
  parameter int unsigned PER_TICKS = 66667,
  parameter int unsigned CW        = $clog2(PER_TICKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic signed [15:0] sin_in,
  input  logic [15:0]        m_idx,
  output logic [2:0]         area,
  output logic               neg,
  output logic               rising,
  output logic               trig,
  output logic               sel_a,
  output logic signed [3:0]  lvl_a,
  output logic signed [3:0]  lvl_b,
  output logic [CW-1:0]      ta_ticks,
  output logic [CW-1:0]      tb_ticks
);
  logic [CW-1:0]      cnt;
  logic               tick;
  logic [14:0]        mag_w;
  logic [2:0]         area_w;
  logic [14:0]        frac_w;
  logic               neg_w;
  logic signed [15:0] ref_w;
  logic               rise_nx;
  logic               rise_q;

  lvl_period_timer #(.PER_TICKS(PER_TICKS), .CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .last(tick));

  lvl_ref_split u_split (
    .sin_in(sin_in), .m_idx(m_idx), .mag(mag_w), .area(area_w),
    .frac(frac_w), .neg(neg_w), .ref_s(ref_w));

  lvl_slope_track u_slope (
    .clk(clk), .rst_n(rst_n), .en(tick), .ref_s(ref_w),
    .rise_nx(rise_nx), .rise_q(rise_q));

  // Named events for checking
  logic          band_move;
  logic          turn_pt;
  logic          a_inner;
  logic [CW-1:0] inner_t;
  logic [CW-1:0] ta_nx;

  logic [2:0]    area_q;
  logic          neg_q;
  logic          trig_q;
  logic [CW-1:0] ta_q;

  assign band_move = (area_w != area_q) || (neg_w != neg_q);
  assign turn_pt   = (rise_nx != rise_q);
  assign a_inner   = rise_nx ^ neg_w;
  assign inner_t   = CW'(inner_ticks(frac_w, 32'(PER_TICKS)));
  assign ta_nx     = a_inner ? inner_t : CW'(PER_TICKS) - inner_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area_q <= 3'd1;
      neg_q  <= 1'b0;
      trig_q <= 1'b0;
      ta_q   <= CW'(PER_TICKS);
    end else if (tick) begin
      area_q <= area_w;
      neg_q  <= neg_w;
      trig_q <= band_move || turn_pt;
      ta_q   <= ta_nx;
    end else begin
      trig_q <= 1'b0;
    end
  end

  logic signed [3:0] kk;
  logic signed [3:0] lo_lv;
  logic signed [3:0] hi_lv;

  assign kk    = $signed({1'b0, area_q});
  assign lo_lv = neg_q ? -kk : kk - 4'sd1;
  assign hi_lv = neg_q ? -(kk - 4'sd1) : kk;

  assign area     = area_q;
  assign neg      = neg_q;
  assign rising   = rise_q;
  assign trig     = trig_q;
  assign lvl_a    = rise_q ? lo_lv : hi_lv;
  assign lvl_b    = rise_q ? hi_lv : lo_lv;
  assign ta_ticks = ta_q;
  assign tb_ticks = CW'(PER_TICKS) - ta_q;
  assign sel_a    = (cnt < ta_q);

  // R8: trigger only in a period's first cycle
  assert_trig_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> (cnt == '0));
  // R8: every band move is announced
  assert_band_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (area_q != $past(area_q)) |-> trig_q);
  // R4: on-time never exceeds the period
  assert_ta_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ta_q <= CW'(PER_TICKS));
  // R9: select drops exactly when A's time is used up
  assert_sel_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_a) |-> (cnt == ta_q));
  // R10: registered outputs move only at a period boundary
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(area_q) && $stable(neg_q) && $stable(ta_q));
endmodule

// File: tb/sim_lvl_dwell_mod.sv
module sim_lvl_dwell_mod;
  localparam int PER = 16;
  localparam int CW  = $clog2(PER + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] sin_in = '0;
  logic [15:0] m_idx = '0;
  logic [2:0] area;
  logic neg, rising, trig, sel_a;
  logic signed [3:0] lvl_a, lvl_b;
  logic [CW-1:0] ta_ticks, tb_ticks;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // expected state
  int e_area = 1, e_neg = 0, e_rise = 1, e_trig = 0, e_ta = PER;
  int e_la = 0, e_lb = 1, e_inner = PER, e_prev = 0;

  always #5 clk = ~clk;

  lvl_dwell_mod #(.PER_TICKS(PER), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sin_in(sin_in), .m_idx(m_idx),
    .area(area), .neg(neg), .rising(rising), .trig(trig), .sel_a(sel_a),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .ta_ticks(ta_ticks), .tb_ticks(tb_ticks));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int s, input int m);
    int a, mc, q, f, r, d, lo, hi;
    a  = (s < 0) ? -s : s;
    mc = (m > 32768) ? 32768 : m;
    q  = (a * mc) / 32768;
    if (q > 32767) q = 32767;
    f = (6 * q) % 32768;
    e_trig = 0;
    if ((6 * q) / 32768 + 1 != e_area) e_trig = 1;
    e_area = (6 * q) / 32768 + 1;
    if (((s < 0) && (q != 0) ? 1 : 0) != e_neg) e_trig = 1;
    e_neg = ((s < 0) && (q != 0)) ? 1 : 0;
    r = e_neg ? -q : q;
    d = r - e_prev;
    e_prev = r;
    if (d > 1 && e_rise == 0) begin e_rise = 1; e_trig = 1; end
    if (d < -1 && e_rise == 1) begin e_rise = 0; e_trig = 1; end
    e_inner = (PER * (32768 - f)) / 32768;
    lo = e_neg ? -e_area : e_area - 1;
    hi = e_neg ? -(e_area - 1) : e_area;
    e_la = e_rise ? lo : hi;
    e_lb = e_rise ? hi : lo;
    e_ta = (e_rise != e_neg) ? e_inner : PER - e_inner;
  endtask

  task automatic check_outputs();
    chk(int'(area) == e_area, "R2 band index", int'(area), e_area);
    chk(int'(neg) == e_neg, "R3 sign", int'(neg), e_neg);
    chk(int'(rising) == e_rise, "R7 direction", int'(rising), e_rise);
    chk((int'(ta_ticks) + int'(tb_ticks) == PER) &&
        (int'(ta_ticks) == e_inner || int'(tb_ticks) == e_inner),
        "R4 dwell split", int'(ta_ticks), e_inner);
    chk(int'(lvl_a) == e_la && int'(lvl_b) == e_lb, "R5 levels",
        int'(lvl_a) * 100 + int'(lvl_b), e_la * 100 + e_lb);
    chk(int'(ta_ticks) == e_ta && int'(tb_ticks) == PER - e_ta,
        "R6 A on-time", int'(ta_ticks), e_ta);
  endtask

  // called at a negedge in the first cycle of a period
  task automatic step(input int s, input int m);
    int highs, trig_hits, stray;
    highs = 0; trig_hits = 0; stray = 0;
    sin_in = 16'(s);
    m_idx  = 16'(m);
    for (int c = 0; c < PER; c++) begin
      if (sel_a !== (c < e_ta)) stray++;
      if (sel_a) highs++;
      if (c == 0) trig_hits = int'(trig);
      else if (trig) stray += 100;
      if (c == PER / 2)
        chk(int'(area) == e_area && int'(ta_ticks) == e_ta, "R10 mid-period hold",
            int'(area), e_area);
      @(posedge clk);
      @(negedge clk);
    end
    chk(stray % 100 == 0, "R9 select pattern", highs, e_ta);
    chk(trig_hits == e_trig && stray < 100, "R8 trigger", trig_hits, e_trig);
    model(s, m);
    check_outputs();
  endtask

  function automatic int tri_wave(input int i);
    int v;
    if (i < 64) v = i * 512;
    else if (i < 192) v = 32768 - (i - 64) * 512;
    else v = -32768 + (i - 192) * 512;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int ms[5];
    ms[0] = 32768; ms[1] = 27197; ms[2] = 19661; ms[3] = 50000; ms[4] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(area == 3'd1 && neg == 1'b0 && rising == 1'b1, "R1 reset flags",
        int'(area), 1);
    chk(trig == 1'b0 && sel_a == 1'b1, "R1 reset trig/select", int'(trig), 0);
    chk(int'(lvl_a) == 0 && int'(lvl_b) == 1, "R1 reset levels",
        int'(lvl_a), 0);
    chk(int'(ta_ticks) == PER && int'(tb_ticks) == 0, "R1 reset on-time",
        int'(ta_ticks), PER);
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 256; i++)
        step(tri_wave(i), ms[k]);
    // R7 deadband plateau
    step(2000, 32768);
    step(1000, 32768);
    step(1001, 32768);
    step(1000, 32768);
    step(1002, 32768);
    step(1003, 32768);
    step(-5, 32768);
    step(-4, 32768);
    step(0, 32768);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule